// File: doc/BRIEF.md
# SECDED-Protected SRAM Controller with Fault Injector

This block sits between a 32-bit bus port with byte enables and a single-port memory that holds 32 data bits and 7 check bits per word. Every write is encoded with a single-error-correct, double-error-detect code, and every read is decoded. Single-bit errors are corrected in the returned data and written back to memory. Double-bit errors are reported but not corrected. The first failing address and its syndrome are captured, sticky status bits are set, and a maskable interrupt is raised.

A fault injector is programmed through the register port with a target word address, a 32-bit flip mask and a single/double mode. While it is armed, the stored data of any write to the target is corrupted after the check bits have been computed. This includes correction write-backs. Writes narrower than a full word are performed as read-modify-write.

Registers, in 3-bit word offsets:
- 0 CTRL: bit0 decode enable, reset value 1.
- 1 INJ_CTRL: bit0 arm, bit1 mode (0 = single, 1 = double).
- 2 INJ_ADDR
- 3 INJ_MASK
- 4 STATUS: bit0 single error, bit1 double error, write 1 to clear.
- 5 IRQ_SET: write 1 to set an enable. Reads return the enables.
- 6 IRQ_CLR: write 1 to clear an enable. Reads return the enables.
- 7 ERR_INFO: bits 6:0 syndrome, bits 8 and up word address.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: After reset, CTRL reads 1, INJ_CTRL, STATUS and the interrupt enables read 0, and `irq` is low.
- R2: With decode enabled, a word written with a full write reads back unchanged and sets no status bit.
- R3: The syndrome captured for a flip of data bit n equals a distinct weight-3 7-bit column. Bit 0 gives 0x61, bits 1 to 4 give 0x62, 0x64, 0x68 and 0x70, and bits 5 to 31 take the remaining weight-3 values in ascending order starting at 0x07. The syndrome is stored check bits XOR recomputed check bits.
- R4: An armed full write to the target stores the data with flipped bits. Single mode flips only the lowest set bit of the mask, and double mode flips the two lowest. For example, 0xA5A5A5A5 with mask 0x1 is stored as 0xA5A5A5A4.
- R5: With decode disabled, reads return the raw stored data and log nothing.
- R6: With decode enabled, a single-bit error is corrected in the returned data, and the corrected word is written back to memory.
- R7: A single-bit error sets STATUS bit0. ERR_INFO holds the address and syndrome of the first error until STATUS is cleared.
- R8: A double-bit error sets STATUS bit1 and returns the uncorrected data. No write-back takes place, and the address and syndrome are captured.
- R9: `irq` is high exactly when some status bit is set and its enable is set. Enables are set through IRQ_SET and cleared through IRQ_CLR.
- R10: Writing 1 to a STATUS bit clears it.
- R11: While armed, writes to INJ_ADDR, INJ_MASK and the mode bit are ignored.
- R12: If the injector is armed when a correction write-back reaches the target, the bits are flipped again.
- R13: A write to the target injects only if its byte enables cover every bit to be flipped.
- R14: A partial write merges the enabled bytes into the decoded old word and re-encodes the full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, accepted while `bus_ready` is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Controller idle |
| bus_done | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with `bus_done` |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a correction write-back that lands on the armed target and corrupts the word again. The only way to create a correctable error is the injector itself, so the stimulus uses it twice. First it arms the injector and writes the target word. It then leaves the injector armed, performs a decoded read so that the corrected write-back passes through the injector, and finally disables decoding to expose the raw word. The same injector is also swept over all 32 data bits, so that each syndrome column can be compared with the value the bench computes itself.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DW = 32;
  localparam int CW = 7;
  localparam int NCOL = 35;
  localparam int ROT = 30;

  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_INJCTL = 3'd1;
  localparam logic [2:0] RA_INJADR = 3'd2;
  localparam logic [2:0] RA_INJMSK = 3'd3;
  localparam logic [2:0] RA_STAT   = 3'd4;
  localparam logic [2:0] RA_IRQSET = 3'd5;
  localparam logic [2:0] RA_IRQCLR = 3'd6;
  localparam logic [2:0] RA_ERRINF = 3'd7;

  typedef enum logic {ST_IDLE, ST_CHK} ctl_state_t;

  // column of the parity-check matrix for data bit i (weight-3 values, rotated)
  function automatic logic [CW-1:0] h_col(input int i);
    logic [CW-1:0] r;
    int cnt;
    int want;
    r = '0;
    cnt = 0;
    want = (i + ROT) % NCOL;
    for (int v = 0; v < 128; v++) begin
      if ($countones(7'(v)) == 3) begin
        if (cnt == want) r = 7'(v);
        cnt++;
      end
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] enc_chk(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) c = c ^ h_col(i);
    return c;
  endfunction

  // lowest set bit of the mask, plus the next one in double mode
  function automatic logic [DW-1:0] pick_flips(input logic [DW-1:0] m, input logic dbl);
    logic [DW-1:0] f;
    int n;
    f = '0;
    n = 0;
    for (int i = 0; i < DW; i++) begin
      if (m[i] && (n == 0 || (dbl && n == 1))) begin
        f[i] = 1'b1;
        n++;
      end
    end
    return f;
  endfunction

  function automatic logic [DW-1:0] be_bits(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/ecc_sram_model.sv
module ecc_sram_model #(
  parameter int AW = 6,
  parameter int W  = 39
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import ecc_pkg::*;
(
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] chk,
  output logic [CW-1:0] syn,
  output logic [DW-1:0] corr,
  output logic          single,
  output logic          double
);
  logic hit;

  assign syn = enc_chk(data) ^ chk;

  always_comb begin
    corr = data;
    hit  = $onehot(syn);
    for (int i = 0; i < DW; i++) begin
      if (syn == h_col(i)) begin
        corr[i] = ~data[i];
        hit     = 1'b1;
      end
    end
  end

  assign single = hit;
  assign double = (syn != '0) && !hit;
endmodule

// File: rtl/ecc_regs.sv
module ecc_regs
  import ecc_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ev_serr,
  input  logic          ev_derr,
  input  logic [AW-1:0] ev_addr,
  input  logic [CW-1:0] ev_syn,
  output logic          decode_en,
  output logic          inj_en,
  output logic          inj_dbl,
  output logic [AW-1:0] inj_addr,
  output logic [DW-1:0] inj_mask,
  output logic [1:0]    status,
  output logic [1:0]    irq_en,
  output logic [AW-1:0] err_addr,
  output logic [CW-1:0] err_syn,
  output logic          irq
);
  logic [1:0] clr;
  logic [1:0] kept;

  assign clr  = (reg_we && reg_addr == RA_STAT) ? reg_wdata[1:0] : 2'b00;
  assign kept = status & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decode_en <= 1'b1;
      inj_en    <= 1'b0;
      inj_dbl   <= 1'b0;
      inj_addr  <= '0;
      inj_mask  <= '0;
      status    <= '0;
      irq_en    <= '0;
      err_addr  <= '0;
      err_syn   <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RA_CTRL:   decode_en <= reg_wdata[0];
          RA_INJCTL: begin
            inj_en <= reg_wdata[0];
            if (!inj_en) inj_dbl <= reg_wdata[1];
          end
          RA_INJADR: if (!inj_en) inj_addr <= reg_wdata[AW-1:0];
          RA_INJMSK: if (!inj_en) inj_mask <= reg_wdata;
          RA_IRQSET: irq_en <= irq_en | reg_wdata[1:0];
          RA_IRQCLR: irq_en <= irq_en & ~reg_wdata[1:0];
          default: ;
        endcase
      end
      status <= kept | {ev_derr, ev_serr};
      if ((ev_serr || ev_derr) && kept == 2'b00) begin
        err_addr <= ev_addr;
        err_syn  <= ev_syn;
      end
    end
  end

  assign irq = |(status & irq_en);

  always_comb begin
    case (reg_addr)
      RA_CTRL:   reg_rdata = {31'd0, decode_en};
      RA_INJCTL: reg_rdata = {30'd0, inj_dbl, inj_en};
      RA_INJADR: reg_rdata = 32'(inj_addr);
      RA_INJMSK: reg_rdata = inj_mask;
      RA_STAT:   reg_rdata = {30'd0, status};
      RA_IRQSET, RA_IRQCLR: reg_rdata = {30'd0, irq_en};
      default:   reg_rdata = 32'(err_syn) | (32'(err_addr) << 8);
    endcase
  end
endmodule

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
  import ecc_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic          bus_ready,
  output logic          bus_done,
  output logic [31:0]   bus_rdata,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq
);
  localparam int WW = DW + CW;

  ctl_state_t    state;
  logic [AW-1:0] q_addr;
  logic          q_we;
  logic [3:0]    q_be;
  logic [DW-1:0] q_wdata;
  logic          done_q;
  logic [DW-1:0] rdata_q;

  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wd;
  logic [WW-1:0] mem_rd;

  logic [CW-1:0] dec_syn;
  logic [DW-1:0] dec_corr;
  logic          dec_single, dec_double;

  logic          decode_en, inj_en, inj_dbl, irq_int;
  logic [AW-1:0] inj_addr, err_addr;
  logic [DW-1:0] inj_mask;
  logic [1:0]    status, irq_en;
  logic [CW-1:0] err_syn;

  // named internal events
  logic          idle, chk_active, full_wr_now;
  logic          ev_serr, ev_derr, ev_wb, ev_inj;
  logic [DW-1:0] old_word, merged, wr_data, wr_cover, flips;

  assign idle        = (state == ST_IDLE);
  assign chk_active  = (state == ST_CHK);
  assign full_wr_now = idle && bus_req && bus_we && (bus_be == 4'hF);

  assign ev_serr = chk_active && decode_en && dec_single;
  assign ev_derr = chk_active && decode_en && dec_double;
  assign ev_wb   = ev_serr && !q_we;

  assign old_word = decode_en ? dec_corr : mem_rd[DW-1:0];
  assign merged   = (q_wdata & be_bits(q_be)) | (old_word & ~be_bits(q_be));

  always_comb begin
    if (idle) begin
      wr_data  = bus_wdata;
      wr_cover = '1;
    end else if (q_we) begin
      wr_data  = merged;
      wr_cover = be_bits(q_be);
    end else begin
      wr_data  = dec_corr;
      wr_cover = '1;
    end
  end

  assign mem_we   = full_wr_now || (chk_active && q_we) || ev_wb;
  assign mem_addr = idle ? bus_addr : q_addr;
  assign flips    = pick_flips(inj_mask, inj_dbl);
  assign ev_inj   = mem_we && inj_en && (mem_addr == inj_addr) && ((flips & ~wr_cover) == '0);
  assign mem_wd   = {enc_chk(wr_data), wr_data ^ (ev_inj ? flips : '0)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      q_addr  <= '0;
      q_we    <= 1'b0;
      q_be    <= '0;
      q_wdata <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= full_wr_now || chk_active;
      if (idle && bus_req) begin
        q_addr  <= bus_addr;
        q_we    <= bus_we;
        q_be    <= bus_be;
        q_wdata <= bus_wdata;
        if (!full_wr_now) state <= ST_CHK;
      end else if (chk_active) begin
        state <= ST_IDLE;
        if (!q_we) rdata_q <= old_word;
      end
    end
  end

  assign bus_ready = idle;
  assign bus_done  = done_q;
  assign bus_rdata = rdata_q;
  assign irq       = irq_int;

  ecc_sram_model #(.AW(AW), .W(WW)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wd(mem_wd), .rd(mem_rd)
  );

  secded_dec u_dec (
    .data(mem_rd[DW-1:0]), .chk(mem_rd[WW-1:DW]), .syn(dec_syn),
    .corr(dec_corr), .single(dec_single), .double(dec_double)
  );

  ecc_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_serr(ev_serr), .ev_derr(ev_derr), .ev_addr(q_addr), .ev_syn(dec_syn),
    .decode_en(decode_en), .inj_en(inj_en), .inj_dbl(inj_dbl),
    .inj_addr(inj_addr), .inj_mask(inj_mask), .status(status), .irq_en(irq_en),
    .err_addr(err_addr), .err_syn(err_syn), .irq(irq_int)
  );
endmodule

// File: rtl/ecc_sram_ctrl_chk.sv
module ecc_sram_ctrl_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          irq,
  input logic          ev_serr,
  input logic          ev_derr,
  input logic          ev_wb,
  input logic          decode_en,
  input logic          inj_en,
  input logic [AW-1:0] inj_addr,
  input logic [31:0]   inj_mask,
  input logic [1:0]    status,
  input logic [AW-1:0] err_addr,
  input logic [6:0]    err_syn
);
  logic [1:0] clr_req;
  assign clr_req = (reg_we && reg_addr == 3'd4) ? reg_wdata[1:0] : 2'b00;

  AST_SERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !clr_req[0]) |=> status[0]); // R7
  AST_SERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_serr |=> status[0]); // R7
  AST_INFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((status != 2'b00) && (clr_req == 2'b00)) |=> ($stable(err_addr) && $stable(err_syn))); // R7
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    inj_en |=> ($stable(inj_mask) && $stable(inj_addr))); // R11
  AST_RAW_NO_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    !decode_en |-> (!ev_serr && !ev_derr)); // R5
  AST_DOUBLE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    ev_derr |-> (!ev_wb && !ev_serr)); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b00) |-> !irq); // R9
endmodule

bind ecc_sram_ctrl ecc_sram_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .ev_serr(ev_serr), .ev_derr(ev_derr),
  .ev_wb(ev_wb), .decode_en(decode_en), .inj_en(inj_en), .inj_addr(inj_addr),
  .inj_mask(inj_mask), .status(status), .err_addr(err_addr), .err_syn(err_syn)
);

// File: tb/test_ecc_sram_ctrl.sv
module test_ecc_sram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, bus_done, irq;
  logic [31:0] bus_rdata, reg_rdata;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ecc_sram_ctrl #(.AW(6)) i_ecc_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // expected column: weight-3 values >= 0x61 first, then the rest ascending
  function automatic logic [6:0] tcol(input int n);
    int k;
    logic [6:0] r;
    k = 0;
    r = '0;
    for (int v = 97; v < 128; v++)
      if ($countones(7'(v)) == 3) begin if (k == n) r = 7'(v); k++; end
    for (int v = 0; v < 97; v++)
      if ($countones(7'(v)) == 3) begin if (k == n) r = 7'(v); k++; end
    return r;
  endfunction

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] bmask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = be[b] ? 8'hFF : 8'h00;
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rwr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rrd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic xfer(input logic we, input logic [5:0] a, input logic [3:0] be,
                      input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk); bus_req = 1'b0;
    while (!bus_done) @(negedge clk);
    q = bus_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] q;
    xfer(1'b1, a, be, d, q);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] q);
    xfer(1'b0, a, 4'h0, 32'h0, q);
  endtask

  task automatic arm(input logic [5:0] a, input logic [31:0] m, input logic dbl);
    rwr(3'd1, 32'd0);
    rwr(3'd2, 32'(a));
    rwr(3'd3, m);
    rwr(3'd1, {30'd0, dbl, 1'b1});
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rrd(3'd0, v); chk("R1 ctrl", v, 32'd1);
    rrd(3'd1, v); chk("R1 injctl", v, 32'd0);
    rrd(3'd4, v); chk("R1 status", v, 32'd0);
    rrd(3'd5, v); chk("R1 irqen", v, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);

    // R2 clean round trip, all addresses
    for (int a = 0; a < 64; a++) wr(6'(a), 4'hF, pat(a));
    for (int a = 0; a < 64; a++) begin rd(6'(a), v); chk("R2 data", v, pat(a)); end
    rrd(3'd4, v); chk("R2 status", v, 32'd0);

    // R4 / R5 / R6 / R7 / R9 / R10 worked example
    arm(6'd5, 32'h1, 1'b0);
    wr(6'd5, 4'hF, 32'hA5A5A5A5);
    rwr(3'd0, 32'd0);
    rd(6'd5, v); chk("R4 raw flipped", v, 32'hA5A5A5A4);
    rrd(3'd4, v); chk("R5 no log", v, 32'd0);
    rwr(3'd0, 32'd1); rwr(3'd1, 32'd0); rwr(3'd5, 32'd1);
    rd(6'd5, v); chk("R6 corrected", v, 32'hA5A5A5A5);
    rrd(3'd4, v); chk("R7 serr", v, 32'd1);
    chk("R9 irq", 32'(irq), 32'd1);
    rrd(3'd7, v); chk("R3 R7 info", v, (32'd5 << 8) | 32'h61);
    rwr(3'd0, 32'd0);
    rd(6'd5, v); chk("R6 written back", v, 32'hA5A5A5A5);
    rwr(3'd0, 32'd1);
    rwr(3'd4, 32'd1);
    rrd(3'd4, v); chk("R10 cleared", v, 32'd0);
    chk("R9 irq low", 32'(irq), 32'd0);

    // R3 syndrome sweep over all data bits
    for (int n = 0; n < 32; n++) begin
      arm(6'd7, 32'd1 << n, 1'b0);
      wr(6'd7, 4'hF, pat(n + 100));
      rwr(3'd1, 32'd0);
      rd(6'd7, v); chk("R3 corrected", v, pat(n + 100));
      rrd(3'd7, v); chk("R3 syndrome", v, (32'd7 << 8) | 32'(tcol(n)));
      rwr(3'd4, 32'd3);
    end

    // R7 first error held
    arm(6'd8, 32'h8, 1'b0); wr(6'd8, 4'hF, pat(8));
    arm(6'd9, 32'h10, 1'b0); wr(6'd9, 4'hF, pat(9));
    rwr(3'd1, 32'd0);
    rd(6'd8, v); rd(6'd9, v);
    rrd(3'd7, v); chk("R7 first held", v, (32'd8 << 8) | 32'(tcol(3)));
    rwr(3'd4, 32'd3);

    // R8 double error, R9 enable clear
    arm(6'd10, 32'h101, 1'b1); wr(6'd10, 4'hF, pat(10));
    rwr(3'd1, 32'd0); rwr(3'd5, 32'd2); rwr(3'd6, 32'd1);
    rd(6'd10, v); chk("R8 uncorrected", v, pat(10) ^ 32'h101);
    rrd(3'd4, v); chk("R8 derr", v, 32'd2);
    rrd(3'd7, v); chk("R8 info", v, (32'd10 << 8) | 32'(tcol(0) ^ tcol(8)));
    chk("R9 derr irq", 32'(irq), 32'd1);
    rwr(3'd0, 32'd0);
    rd(6'd10, v); chk("R8 no writeback", v, pat(10) ^ 32'h101);
    rwr(3'd0, 32'd1);
    rwr(3'd6, 32'd2);
    chk("R9 irq masked", 32'(irq), 32'd0);
    rrd(3'd4, v); chk("R9 status kept", v, 32'd2);
    rwr(3'd4, 32'd2);

    // R4 single mode keeps only lowest mask bit
    arm(6'd11, 32'h30, 1'b0); wr(6'd11, 4'hF, pat(11));
    rwr(3'd1, 32'd0); rwr(3'd0, 32'd0);
    rd(6'd11, v); chk("R4 single lowest", v, pat(11) ^ 32'h10);
    rwr(3'd0, 32'd1);
    rd(6'd11, v); rwr(3'd4, 32'd3);

    // R11 lock while armed
    arm(6'd12, 32'h4, 1'b0);
    rwr(3'd2, 32'd13); rwr(3'd3, 32'h8); rwr(3'd1, 32'd3);
    rrd(3'd2, v); chk("R11 addr", v, 32'd12);
    rrd(3'd3, v); chk("R11 mask", v, 32'h4);
    rrd(3'd1, v); chk("R11 mode", v, 32'd1);
    rwr(3'd1, 32'd0);

    // R12 re-injection by write-back
    arm(6'd14, 32'h2, 1'b0); wr(6'd14, 4'hF, pat(14));
    rd(6'd14, v); chk("R12 corrected out", v, pat(14));
    rwr(3'd0, 32'd0);
    rd(6'd14, v); chk("R12 reflipped", v, pat(14) ^ 32'h2);
    rwr(3'd1, 32'd0); rwr(3'd0, 32'd1); rwr(3'd4, 32'd3);

    // R13 byte enable qualification
    arm(6'd15, 32'h00010000, 1'b0);
    wr(6'd15, 4'h1, 32'h000000C3);
    d = (pat(15) & 32'hFFFFFF00) | 32'hC3;
    rwr(3'd0, 32'd0);
    rd(6'd15, v); chk("R13 no inject", v, d);
    rwr(3'd0, 32'd1);
    wr(6'd15, 4'h4, 32'h005A0000);
    d = (d & 32'hFF00FFFF) | 32'h005A0000;
    rwr(3'd1, 32'd0); rwr(3'd0, 32'd0);
    rd(6'd15, v); chk("R13 injected", v, d ^ 32'h00010000);
    rwr(3'd0, 32'd1);
    rd(6'd15, v); chk("R13 corrected", v, d);
    rwr(3'd4, 32'd3);

    // R14 read-modify-write merge sweep over all byte enables
    for (int be = 0; be < 16; be++) begin
      wr(6'd20, 4'hF, pat(be + 200));
      wr(6'd20, 4'(be), 32'hC0DE1234 ^ 32'(be));
      rd(6'd20, v);
      chk("R14 merge", v, ((32'hC0DE1234 ^ 32'(be)) & bmask(4'(be))) |
                          (pat(be + 200) & ~bmask(4'(be))));
    end
    rrd(3'd4, v); chk("R14 clean", v, 32'd0);

    finish_run();
  end
endmodule